// File: doc/BRIEF.md
# Serial Peripheral Master with Decoded Device Selects

This block is a full-duplex synchronous serial master. A word written by the host is sent most significant bit first on the data output. On the same serial clock, the bit stream from the addressed slave is shifted in. The serial clock runs at the system clock divided by twice a 16-bit divisor that the host sets. Clock idle level and sampling edge are both programmable, so all four common clocking modes are available. Words are 8 or 16 bits long.

A three-bit device field in the control register picks one of seven active-low select outputs. That output goes low only while a transfer runs. Writing zero to the field lets a transfer run with no device selected.

The block watches an active-low slave-select input. If another master pulls it low while this port is enabled, any transfer in progress is abandoned and the serial clock returns to its idle level. A sticky fault bit is also set. The host reaches five registers through a simple word-wide read/write port: control, divisor, transmit data, receive data and status.

Top module: `spi_host_master`

## Requirements
- R1: The serial clock holds each level for exactly DIV system clock cycles, where DIV is the divisor register (address 1), so one serial period is 2×DIV cycles. The first edge comes DIV cycles after the transfer starts.
- R2: A divisor write of 0 or 1 stores 2. Any write from 2 to 65,535 stores the written value. The register reads back at address 1 and resets to 2.
- R3: Control bit 3 chooses the word length: 0 gives 8 bits, 1 gives 16 bits. Each transfer shifts the transmit word (address 2) out MSB first while shifting the same number of bits in from the slave. The received word reads at address 3, right-aligned, with upper bits zero in 8-bit mode.
- R4: Control bit 1 sets the serial clock idle level, which the clock holds whenever no transfer runs. With control bit 2 clear, the first data bit is driven before the first edge, input is sampled on the leading edge of each bit and output changes on the trailing edge. With bit 2 set, output changes on the leading edge and input is sampled on the trailing edge.
- R5: Control bits 6:4 hold a device number. For a value of 1 to 7, select output n−1 is driven low during the transfer only. For 0, no output goes low. All select outputs are high whenever no transfer runs.
- R6: Status bit 0 (busy) goes high in the cycle after a transmit write and stays high for exactly 2×W×DIV cycles, where W is the word length. A transmit write is ignored while busy, while control bit 0 (enable) is clear, or while the fault bit is set.
- R7: Status bit 1 (receive full) sets when a transfer completes. It stays set until the receive register is read.
- R8: While enabled, a low slave-select input (seen after two synchroniser cycles) stops any transfer and returns the serial clock to idle. It also releases all selects and sets status bit 2. That bit stays set until the host writes status with bit 2 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (clears receive full on address 3) |
| host_addr | input | 3 | Register address: 0 control, 1 divisor, 2 transmit, 3 receive, 4 status |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave-select input from another master |
| cs_n | output | 7 | Active-low device selects |

## Verification
Errors in the divider counter or the edge counter show up at once as the wrong busy length and the wrong spacing between serial clock edges. Both are measured on the first transfer after reset. If the bit pointer or the choice of sampling edge is wrong, the word captured by the slave model or the received word is corrupted. This appears within one transfer in the clocking mode concerned, so every transfer compares both directions. Fault and select-decoder faults show within a few cycles as a serial clock away from idle, a select held low, or a fault bit that clears or fails to set.

// File: rtl/spi_host_pkg.sv
// Package: register addresses and control/status bit positions shared by
// the serial master and its bench-facing register file.
// Assumes a 3-bit host address and a 16-bit register word.
package spi_host_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV    = 3'd1;
    localparam logic [ADDR_W-1:0] A_TX     = 3'd2;
    localparam logic [ADDR_W-1:0] A_RX     = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    localparam int C_EN    = 0;
    localparam int C_CPOL  = 1;
    localparam int C_CPHA  = 2;
    localparam int C_WIDE  = 3;
    localparam int C_SEL   = 4;

    localparam int S_BUSY  = 0;
    localparam int S_FULL  = 1;
    localparam int S_FAULT = 2;
endpackage

// File: rtl/spi_clk_div.sv
// Module: half-period timer for the serial clock.
// Emits a one-cycle tick every DIV cycles while run is high. The counter is
// held at zero while idle. Assumes div >= 2; the register file guarantees it.
module spi_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Tick when the count reaches the last cycle of a half period.
    always_comb tick = run && (cnt_q >= div - DIV_W'(1));

    // Half-period counter, cleared on tick or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run||tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + DIV_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
endmodule

// File: rtl/spi_shift_engine.sv
// Module: bit-level transfer engine.
// Counts serial clock edges and alternates between sample and shift edges as
// the clock phase setting dictates. Shifts out MSB first and assembles the
// received word. Assumes start is only honoured while idle and that the
// control inputs stay stable during a transfer.
module spi_shift_engine #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              wide,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic              abort,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int HALF_W = DATA_W / 2;
    localparam int EDGE_W = $clog2(2 * DATA_W);
    localparam int PTR_W  = $clog2(DATA_W) + 1;

    logic              busy_q, phase_q, mosi_q, done_q;
    logic [EDGE_W-1:0] edge_q, last_edge;
    logic [PTR_W-1:0]  ptr_q, top_idx;
    logic [DATA_W-1:0] tx_q, rx_sr, rx_next, rx_fit, rx_q;
    logic              sample_edge, ptr_neg;

    // Word-length dependent limits.
    always_comb begin
        last_edge = wide ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(2 * HALF_W - 1);
        top_idx   = wide ? PTR_W'(DATA_W - 1)      : PTR_W'(HALF_W - 1);
    end

    // Even edges lead; sample on leading edges for phase 0, trailing for 1.
    always_comb begin
        sample_edge = (~edge_q[0]) ^ cpha;
        ptr_neg     = ptr_q[PTR_W-1];
        rx_next     = sample_edge ? {rx_sr[DATA_W-2:0], miso} : rx_sr;
        rx_fit      = wide ? rx_next : {{HALF_W{1'b0}}, rx_next[HALF_W-1:0]};
    end

    // Transfer sequencing: start, per-edge shifting, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
            ptr_q   <= '0;
            tx_q    <= '0;
            rx_sr   <= '0;
            rx_q    <= '0;
            mosi_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q  <= 1'b0;
                phase_q <= 1'b0;
                edge_q  <= '0;
            end else if (start && !busy_q) begin
                busy_q  <= 1'b1;
                phase_q <= 1'b0;
                edge_q  <= '0;
                tx_q    <= tx_word;
                rx_sr   <= '0;
                if (!cpha) begin
                    mosi_q <= tx_word[top_idx[PTR_W-2:0]];
                    ptr_q  <= top_idx - PTR_W'(1);
                end else begin
                    ptr_q  <= top_idx;
                end
            end else if (busy_q && tick) begin
                phase_q <= ~phase_q;
                edge_q  <= edge_q + EDGE_W'(1);
                rx_sr   <= rx_next;
                if (!sample_edge && !ptr_neg) begin
                    mosi_q <= tx_q[ptr_q[PTR_W-2:0]];
                    ptr_q  <= ptr_q - PTR_W'(1);
                end
                if (edge_q == last_edge) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    rx_q   <= rx_fit;
                end
            end
        end
    end

    // Drive outputs from the state registers.
    always_comb begin
        busy    = busy_q;
        sck     = cpol ^ phase_q;
        mosi    = mosi_q;
        done    = done_q;
        rx_word = rx_q;
    end

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (sck == cpol)); // R4
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy_q); // R8
    AST_SCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tick && !abort) |=> $stable(phase_q)); // R1
endmodule

// File: rtl/spi_cs_decode.sv
// Module: device-select decoder.
// Turns the device number into active-low selects. Output n-1 is low for
// device n only while active; device 0 selects nothing.
module spi_cs_decode #(
    parameter int NUM_CS = 7,
    parameter int SEL_W  = $clog2(NUM_CS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        // One select line per device number.
        always_comb cs_n[i] = !(active && (sel == SEL_W'(i + 1)));
    end

    AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R5
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (&cs_n)); // R5
endmodule

// File: rtl/spi_host_master.sv
// Module: top of the serial master.
// Holds the host-visible registers, synchronises the slave-select input,
// and connects the divider, shift engine and select decoder.
// Assumes single-cycle host strobes and a combinational read path.
module spi_host_master
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 16,
    parameter int NUM_CS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    input  logic              ss_n,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int SEL_W = $clog2(NUM_CS + 1);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic             en_q, cpol_q, cpha_q, wide_q;
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_q;
    logic             full_q, fault_q;
    logic             ss_meta_q, ss_sync_q;
    logic             busy, tick, done, abort, start, fault_clr;
    logic [DATA_W-1:0] rx_word;

    // Two-stage synchroniser for the external slave-select input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_meta_q <= 1'b1;
            ss_sync_q <= 1'b1;
        end else begin
            ss_meta_q <= ss_n;
            ss_sync_q <= ss_meta_q;
        end
    end

    // Decode of abort, start and fault-clear requests.
    always_comb begin
        abort     = en_q && !ss_sync_q;
        start     = host_wr && (host_addr == A_TX) && en_q && !fault_q && !abort;
        fault_clr = host_wr && (host_addr == A_STATUS) && host_wdata[S_FAULT];
    end

    // Control and divisor registers; divisor clamps to its legal minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            wide_q <= 1'b0;
            sel_q  <= '0;
            div_q  <= DIV_MIN;
        end else if (host_wr) begin
            if (host_addr == A_CTRL) begin
                en_q   <= host_wdata[C_EN];
                cpol_q <= host_wdata[C_CPOL];
                cpha_q <= host_wdata[C_CPHA];
                wide_q <= host_wdata[C_WIDE];
                sel_q  <= host_wdata[C_SEL +: SEL_W];
            end
            if (host_addr == A_DIV)
                div_q <= (host_wdata[DIV_W-1:0] < DIV_MIN) ? DIV_MIN : host_wdata[DIV_W-1:0];
        end
    end

    // Receive-full and sticky fault flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (done)                                    full_q <= 1'b1;
            else if (host_rd && (host_addr == A_RX))     full_q <= 1'b0;
            if (abort)          fault_q <= 1'b1;
            else if (fault_clr) fault_q <= 1'b0;
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CTRL: begin
                host_rdata[C_EN]           = en_q;
                host_rdata[C_CPOL]         = cpol_q;
                host_rdata[C_CPHA]         = cpha_q;
                host_rdata[C_WIDE]         = wide_q;
                host_rdata[C_SEL +: SEL_W] = sel_q;
            end
            A_DIV:    host_rdata = DATA_W'(div_q);
            A_RX:     host_rdata = rx_word;
            A_STATUS: begin
                host_rdata[S_BUSY]  = busy;
                host_rdata[S_FULL]  = full_q;
                host_rdata[S_FAULT] = fault_q;
            end
            default:  host_rdata = '0;
        endcase
    end

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(host_wdata),
        .wide(wide_q), .cpol(cpol_q), .cpha(cpha_q), .tick(tick),
        .abort(abort), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
        .done(done), .rx_word(rx_word)
    );

    spi_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
        .clk(clk), .rst_n(rst_n), .active(busy), .sel(sel_q), .cs_n(cs_n)
    );

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= DIV_MIN); // R2
    AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full_q); // R7
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !fault_clr) |=> fault_q); // R8
    AST_FAULT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !busy) |=> !busy); // R6
endmodule

// File: tb/tb_spi_host_master.sv
module tb_spi_host_master;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_TX = 3'd2,
                           A_RX = 3'd3, A_STATUS = 3'd4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        sck, mosi, miso = 1'b0, ss_n = 1'b1;
    logic [6:0]  cs_n;

    int checks = 0, errors = 0, n_xfer = 0, mon_count = 0;
    bit finished = 0;

    typedef struct { logic [15:0] rx; logic [15:0] tx; logic [15:0] mask; } exp_t;
    exp_t sb_q[$];
    event xfer_end;

    // Slave model state
    bit          s_active = 0, b_cpol = 0, b_cpha = 0;
    logic [15:0] s_word = '0, s_cap = '0;
    int          s_ptr = 0, s_edges = 0;
    time         t_first = 0, t_second = 0;

    spi_host_master dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave model: samples on the sample edge, drives the next bit on the other.
    always @(sck) begin
        if (s_active) begin
            if (s_edges == 0) t_first = $time;
            if (s_edges == 1) t_second = $time;
            s_edges++;
            if ((sck != b_cpol) != b_cpha) s_cap = {s_cap[14:0], mosi};
            else if (s_ptr >= 0) begin
                miso = s_word[s_ptr];
                s_ptr--;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Monitor: pops the expected item at each completion and compares.
    initial begin
        forever begin
            exp_t it;
            logic [15:0] st, rd;
            @(xfer_end);
            it = sb_q.pop_front();
            bus_rd(A_STATUS, st);
            chk("R7 full set after transfer", st[1], 1'b1);
            bus_rd(A_RX, rd);
            chk("R3 received word", rd, it.rx);
            chk("R3 word seen by slave", s_cap & it.mask, it.tx);
            bus_rd(A_STATUS, st);
            chk("R7 full cleared by read", st[1], 1'b0);
            mon_count++;
        end
    end

    // Driver: configures, pushes the expectation, runs one transfer.
    task automatic run_xfer(input bit cpol, input bit cpha, input bit wide,
                            input int sel, input int div,
                            input logic [15:0] txw, input logic [15:0] rxw,
                            input bit inject);
        logic [15:0] st, mask;
        int w, cnt;
        exp_t it;
        w = wide ? 16 : 8;
        mask = wide ? 16'hFFFF : 16'h00FF;
        bus_wr(A_DIV, 16'(div));
        bus_wr(A_CTRL, {9'd0, 3'(sel), wide, cpha, cpol, 1'b1});
        chk("R4 idle level before transfer", sck, cpol);
        b_cpol = cpol; b_cpha = cpha; s_word = rxw; s_cap = '0; s_edges = 0;
        if (!cpha) begin miso = rxw[w-1]; s_ptr = w - 2; end
        else s_ptr = w - 1;
        s_active = 1;
        it.rx = rxw & mask; it.tx = txw & mask; it.mask = mask;
        sb_q.push_back(it);
        bus_wr(A_TX, txw);
        cnt = 0;
        forever begin
            bus_rd(A_STATUS, st);
            if (!st[0]) break;
            if (cnt == 0)
                chk("R5 select during transfer", cs_n,
                    (sel == 0) ? 7'h7F : 7'(~(7'b1 << (sel - 1))));
            cnt++;
            if (inject && cnt == 3) begin
                bus_wr(A_TX, ~txw);   // R6: must be ignored while busy
                cnt++;
            end
        end
        chk("R6 busy length", cnt, 2 * w * div);
        chk("R1 half period", t_second - t_first, div * CLK_PERIOD);
        chk("R5 selects released", cs_n, 7'h7F);
        chk("R4 idle level after transfer", sck, cpol);
        s_active = 0;
        n_xfer++;
        -> xfer_end;
        wait (mon_count == n_xfer);
    endtask

    initial begin
        logic [15:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(A_STATUS, st);
        chk("R7 reset status", st, 16'h0);
        chk("R5 reset selects", cs_n, 7'h7F);
        chk("R4 reset clock idle", sck, 1'b0);
        bus_rd(A_DIV, st);
        chk("R2 reset divisor", st, 16'd2);

        bus_wr(A_DIV, 16'd0); bus_rd(A_DIV, st); chk("R2 clamp of 0", st, 16'd2);
        bus_wr(A_DIV, 16'd1); bus_rd(A_DIV, st); chk("R2 clamp of 1", st, 16'd2);
        bus_wr(A_DIV, 16'd5); bus_rd(A_DIV, st); chk("R2 plain value", st, 16'd5);
        bus_wr(A_DIV, 16'hFFFF); bus_rd(A_DIV, st); chk("R2 top value", st, 16'hFFFF);

        bus_wr(A_CTRL, 16'h0030);              // disabled, device 3
        bus_wr(A_TX, 16'h00A5);
        bus_rd(A_STATUS, st);
        chk("R6 write ignored while disabled", st[0], 1'b0);
        chk("R5 no select while disabled", cs_n, 7'h7F);

        run_xfer(0, 0, 0, 3, 2, 16'h00A5, 16'h003C, 1);
        run_xfer(1, 1, 1, 7, 3, 16'h8137, 16'hF00D, 0);
        run_xfer(0, 1, 0, 0, 2, 16'h0096, 16'h0069, 0);
        run_xfer(1, 0, 1, 1, 2, 16'h4C21, 16'hB3DE, 0);

        // R8: mode fault from another master
        bus_wr(A_DIV, 16'd4);
        bus_wr(A_CTRL, {9'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1});
        bus_wr(A_TX, 16'h005A);
        repeat (5) @(negedge clk);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd(A_STATUS, st);
        chk("R8 transfer stopped", st[0], 1'b0);
        chk("R8 fault set", st[2], 1'b1);
        chk("R8 clock back to idle", sck, 1'b1);
        chk("R8 selects released", cs_n, 7'h7F);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_rd(A_STATUS, st);
        chk("R8 fault sticky", st[2], 1'b1);
        bus_wr(A_TX, 16'h0011);
        bus_rd(A_STATUS, st);
        chk("R6 write ignored while faulted", st[0], 1'b0);
        bus_wr(A_STATUS, 16'h0004);
        bus_rd(A_STATUS, st);
        chk("R8 fault cleared", st[2], 1'b0);

        run_xfer(0, 0, 1, 5, 2, 16'h1234, 16'hCAFE, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule